// File: doc/BRIEF.md
# Pipelined burst SRAM

A single-port synchronous memory of 32-bit words split into four byte lanes, with a registered read pipeline and a 2-bit burst address generator. All control inputs are sampled on the rising clock edge. A transfer begins when one of two address strobes is taken while the device is selected. The strobe loads the full address, and its two low bits seed the burst counter. On later cycles without a strobe, the advance input steps the counter through the four words of the aligned group. When advance is high, the counter holds and the same word is accessed again.

The high-priority strobe always starts a read and is gated by the first chip enable. The low-priority strobe takes the write controls into account. A write either covers all four lanes through a global override, or covers the lanes picked by active-low lane selects qualified by a byte-write enable. Read data comes out one cycle after its address is registered. Separate write-data and read-data ports replace a shared bus. An output-valid flag, gated by an asynchronous active-low output enable, takes the place of a drive direction. The first read after a deselected state is suppressed at the output.

Top module: `burst_sram`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it rises, `rvalid_o` is 0 and `rdata_o` is 0, and no access is active until a strobe is taken.
- R2: The device counts as selected only when `en_a_n_i`=0, `en_b_i`=1 and `en_c_n_i`=0 at the edge where a strobe is taken. A strobe taken while not selected ends any access, and later strobe-free cycles neither read nor write.
- R3: A taken strobe accesses the word at `addr_i` in that cycle, latches `addr_i[ADDR_W-1:2]`, and loads `addr_i[1:0]` into the burst counter.
- R4: When both strobes are low and `en_a_n_i`=0, only `strb_hi_n_i` acts. The cycle is a read, and every write control is ignored.
- R5: `strb_hi_n_i` is ignored while `en_a_n_i`=1. If `strb_lo_n_i` is high, a running burst goes on as if no strobe were present.
- R6: On an active cycle with no strobe and `adv_n_i`=0, the counter increments in linear order and wraps from 3 to 0 before the access. The upper address bits stay unchanged.
- R7: On an active cycle with no strobe and `adv_n_i`=1, the previous word is accessed again.
- R8: A write cycle with `wr_all_n_i`=0 writes all four lanes, whatever `wr_byte_n_i` and `lane_sel_n_i` hold.
- R9: With `wr_all_n_i`=1, lane i (bits 8i+7:8i) is written only when `wr_byte_n_i`=0 and `lane_sel_n_i[i]`=0. A cycle with no lane enabled is a read.
- R10: For a read of address A at edge k, `rdata_o` holds mem[A] and `rvalid_o`=1 after edge k+1, provided `oe_n_i`=0. Data written at edge k+1 is not yet seen.
- R11: Whenever `oe_n_i`=1, `rvalid_o`=0 and `rdata_o`=0, without waiting for a clock edge.
- R12: A read started by a strobe that is taken while no access is active never raises `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| strb_hi_n_i | input | 1 | High-priority read strobe, active low |
| strb_lo_n_i | input | 1 | Low-priority strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| en_a_n_i | input | 1 | Enable A, active low, also gates the high-priority strobe |
| en_b_i | input | 1 | Enable B, active high |
| en_c_n_i | input | 1 | Enable C, active low |
| wr_all_n_i | input | 1 | Global write, active low |
| wr_byte_n_i | input | 1 | Byte-write enable, active low |
| lane_sel_n_i | input | 4 | Lane selects, active low |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
The assertions check, on every cycle, the local access rules. No write may occur under the high-priority strobe, and a deselecting strobe produces no access. The burst address has to increment with wrap or hold as advance dictates, and valid output must follow a read registered two edges before. Data integrity can only be shown by the bench scenarios against a reference memory. These cover lane merging, strobe priority as seen through later reads, suppression of the first read after deselect, and the ordering of a write against a read of the same word one edge apart.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strb_hi_n_i,
  input  logic              strb_lo_n_i,
  input  logic              adv_n_i,
  input  logic              en_a_n_i,
  input  logic              en_b_i,
  input  logic              en_c_n_i,
  input  logic              wr_req_i,
  output acc_e              acc_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              first_o
);
  localparam int HI_W = ADDR_W - 2;

  logic            active_q;
  logic [HI_W-1:0] hi_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_nxt;
  logic            sel, hi_take, lo_take, strobe;

  always_comb begin
    sel     = !en_a_n_i && en_b_i && !en_c_n_i;
    hi_take = !strb_hi_n_i && !en_a_n_i;
    lo_take = !strb_lo_n_i && !hi_take;
    strobe  = hi_take || lo_take;
    cnt_nxt = adv_n_i ? cnt_q : cnt_q + 2'd1;

    acc_o      = ACC_NONE;
    acc_addr_o = {hi_q, cnt_nxt};
    first_o    = 1'b0;
    if (strobe) begin
      acc_addr_o = addr_i;
      if (sel) begin
        // high-priority strobe always opens with a read
        acc_o   = (!hi_take && wr_req_i) ? ACC_WRITE : ACC_READ;
        first_o = !active_q;
      end
    end else if (active_q) begin
      acc_o = wr_req_i ? ACC_WRITE : ACC_READ;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hi_q     <= '0;
      cnt_q    <= '0;
    end else if (strobe) begin
      active_q <= sel;
      if (sel) begin
        hi_q  <= addr_i[ADDR_W-1:2];
        cnt_q <= addr_i[1:0];
      end
    end else if (active_q) begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/burst_sram_lanes.sv
module burst_sram_lanes #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n_i,
  input  logic             wr_byte_n_i,
  input  logic [LANES-1:0] lane_sel_n_i,
  output logic [LANES-1:0] mask_o,
  output logic             wr_req_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_o[g] = !wr_all_n_i || (!wr_byte_n_i && !lane_sel_n_i[g]);
  end
  assign wr_req_o = |mask_o;
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  acc_e                    acc_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    first_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    dvld_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              rq_v, rq_first, vld_q;
  logic [ADDR_W-1:0] rq_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_v     <= 1'b0;
      rq_first <= 1'b0;
      rq_addr  <= '0;
      vld_q    <= 1'b0;
    end else begin
      rq_v     <= (acc_i == ACC_READ);
      rq_first <= first_i;
      rq_addr  <= addr_i;
      vld_q    <= rq_v && !rq_first;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] dout_q;
    always_ff @(posedge clk_i) begin
      if (acc_i == ACC_WRITE && mask_i[g]) bank[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      dout_q <= bank[rq_addr];
    end
    assign dout_o[g*LANE_W +: LANE_W] = dout_q;
  end

  assign dvld_o = vld_q;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    strb_hi_n_i,
  input  logic                    strb_lo_n_i,
  input  logic                    adv_n_i,
  input  logic                    en_a_n_i,
  input  logic                    en_b_i,
  input  logic                    en_c_n_i,
  input  logic                    wr_all_n_i,
  input  logic                    wr_byte_n_i,
  input  logic [LANES-1:0]        lane_sel_n_i,
  input  logic                    oe_n_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int DATA_W = LANES * LANE_W;

  acc_e              acc_w;
  logic [ADDR_W-1:0] acc_addr_w;
  logic              first_w, wr_req_w, dvld_w;
  logic [LANES-1:0]  mask_w;
  logic [DATA_W-1:0] dout_w;

  burst_sram_lanes #(.LANES(LANES)) u_lanes (
    .wr_all_n_i  (wr_all_n_i),
    .wr_byte_n_i (wr_byte_n_i),
    .lane_sel_n_i(lane_sel_n_i),
    .mask_o      (mask_w),
    .wr_req_o    (wr_req_w)
  );

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .strb_hi_n_i(strb_hi_n_i),
    .strb_lo_n_i(strb_lo_n_i),
    .adv_n_i    (adv_n_i),
    .en_a_n_i   (en_a_n_i),
    .en_b_i     (en_b_i),
    .en_c_n_i   (en_c_n_i),
    .wr_req_i   (wr_req_w),
    .acc_o      (acc_w),
    .acc_addr_o (acc_addr_w),
    .first_o    (first_w)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc_w),
    .addr_i (acc_addr_w),
    .first_i(first_w),
    .mask_i (mask_w),
    .wdata_i(wdata_i),
    .dout_o (dout_w),
    .dvld_o (dvld_w)
  );

  // output enable acts without a clock
  assign rvalid_o = dvld_w && !oe_n_i;
  assign rdata_o  = rvalid_o ? dout_w : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strb_hi_n_i,
  input logic              strb_lo_n_i,
  input logic              adv_n_i,
  input logic              en_a_n_i,
  input logic              en_b_i,
  input logic              en_c_n_i,
  input logic              rvalid_o,
  input acc_e              acc_i,
  input logic [ADDR_W-1:0] acc_addr_i
);
  logic sel, hi_tk, any_tk;
  assign sel    = !en_a_n_i && en_b_i && !en_c_n_i;
  assign hi_tk  = !strb_hi_n_i && !en_a_n_i;
  assign any_tk = hi_tk || !strb_lo_n_i;

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_quiet_r1: assert (!rvalid_o);
  end

  p_desel_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_tk && !sel) |-> (acc_i == ACC_NONE));

  p_hi_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_tk |-> (acc_i != ACC_WRITE));

  p_burst_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_tk && !adv_n_i && acc_i != ACC_NONE && $past(acc_i != ACC_NONE))
    |-> (acc_addr_i[1:0] == 2'($past(acc_addr_i[1:0]) + 2'd1)
         && acc_addr_i[ADDR_W-1:2] == $past(acc_addr_i[ADDR_W-1:2])));

  p_burst_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_tk && adv_n_i && acc_i != ACC_NONE && $past(acc_i != ACC_NONE))
    |-> $stable(acc_addr_i));

  p_read_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(acc_i == ACC_READ, 2));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strb_hi_n_i(strb_hi_n_i),
  .strb_lo_n_i(strb_lo_n_i),
  .adv_n_i    (adv_n_i),
  .en_a_n_i   (en_a_n_i),
  .en_b_i     (en_b_i),
  .en_c_n_i   (en_c_n_i),
  .rvalid_o   (rvalid_o),
  .acc_i      (acc_w),
  .acc_addr_i (acc_addr_w)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic strb_hi_n_i = 1, strb_lo_n_i = 1, adv_n_i = 1;
  logic en_a_n_i = 0, en_b_i = 1, en_c_n_i = 0;
  logic wr_all_n_i = 1, wr_byte_n_i = 1, oe_n_i = 0;
  logic [3:0]  lane_sel_n_i = 4'hF;
  logic [31:0] wdata_i = '0, rdata_o;
  logic rvalid_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] ref_mem [DEPTH];
  logic m_act = 0, q_v = 0, o_v = 0;
  int m_hi = 0, m_cnt = 0, q_a = 0;
  logic [31:0] o_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .strb_hi_n_i(strb_hi_n_i),
    .strb_lo_n_i(strb_lo_n_i), .adv_n_i(adv_n_i), .en_a_n_i(en_a_n_i), .en_b_i(en_b_i),
    .en_c_n_i(en_c_n_i), .wr_all_n_i(wr_all_n_i), .wr_byte_n_i(wr_byte_n_i),
    .lane_sel_n_i(lane_sel_n_i), .oe_n_i(oe_n_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o));

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask();
    if (!wr_all_n_i) return 4'hF;
    if (!wr_byte_n_i) return ~lane_sel_n_i;
    return 4'h0;
  endfunction

  task automatic idle();
    strb_hi_n_i = 1; strb_lo_n_i = 1; adv_n_i = 1;
    en_a_n_i = 0; en_b_i = 1; en_c_n_i = 0;
    wr_all_n_i = 1; wr_byte_n_i = 1; lane_sel_n_i = 4'hF; oe_n_i = 0;
  endtask

  // one clock: reference model update, then compare after the edge
  task automatic cycle(input string req);
    logic sel, hv, lv, st, wr, acc, fst;
    logic [3:0] m;
    int a;
    logic exp_v;
    logic [31:0] exp_d;
    sel = !en_a_n_i && en_b_i && !en_c_n_i;
    hv  = !strb_hi_n_i && !en_a_n_i;
    lv  = !strb_lo_n_i && !hv;
    st  = hv || lv;
    m   = exp_mask();
    wr  = |m;
    acc = 0; fst = 0; a = 0;
    if (st) begin
      if (sel) begin
        acc = 1; a = int'(addr_i); fst = !m_act; wr = wr && !hv;
        m_hi = int'(addr_i) >> 2; m_cnt = int'(addr_i) & 3;
      end
      m_act = sel;
    end else if (m_act) begin
      if (!adv_n_i) m_cnt = (m_cnt + 1) % 4;
      a = m_hi * 4 + m_cnt; acc = 1;
    end
    o_v = q_v;
    o_d = ref_mem[q_a];
    if (acc && wr)
      for (int i = 0; i < 4; i++)
        if (m[i]) ref_mem[a][i*8 +: 8] = wdata_i[i*8 +: 8];
    q_v = acc && !wr && !fst;
    q_a = a;
    @(posedge clk);
    @(negedge clk);
    exp_v = o_v && !oe_n_i;
    exp_d = exp_v ? o_d : 32'h0;
    check(req, rvalid_o === exp_v, {31'h0, rvalid_o}, {31'h0, exp_v});
    check(req, rdata_o === exp_d, rdata_o, exp_d);
  endtask

  task automatic lo_strobe(input int a, input string req);
    idle(); strb_lo_n_i = 0; addr_i = ADDR_W'(a); cycle(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
    repeat (3) @(negedge clk);
    check("R1", rvalid_o === 1'b0 && rdata_o === 32'h0, rdata_o, 32'h0);
    rst_ni = 1;
    idle(); cycle("R1");

    // fill memory with global writes; lane selects set to "none" show override
    for (int i = 0; i < DEPTH; i++) begin
      idle(); strb_lo_n_i = 0; addr_i = ADDR_W'(i);
      wr_all_n_i = 0; wr_byte_n_i = 1; lane_sel_n_i = 4'hF; wdata_i = $urandom;
      cycle("R8");
    end

    // single read: now active, result next cycle
    lo_strobe(8'h05, "R3"); idle(); adv_n_i = 1; strb_lo_n_i = 1; cycle("R10");

    // deselect via enable C, writes afterwards ignored
    idle(); strb_lo_n_i = 0; en_c_n_i = 1; addr_i = 8'h20; cycle("R2");
    idle(); wr_all_n_i = 0; wdata_i = 32'hDEAD_BEEF; cycle("R2");
    idle(); cycle("R2");
    // first read after deselect is masked, repeat read is not
    lo_strobe(8'h21, "R12"); idle(); cycle("R12"); idle(); cycle("R12");
    lo_strobe(8'h20, "R2"); idle(); cycle("R2"); idle(); cycle("R2");

    // burst with wrap: 0x12,0x13,0x10,0x11
    lo_strobe(8'h12, "R6");
    for (int i = 0; i < 4; i++) begin idle(); adv_n_i = 0; cycle("R6"); end
    idle(); cycle("R7"); idle(); cycle("R7");

    // byte-masked write then read back
    idle(); strb_lo_n_i = 0; addr_i = 8'h40; wr_byte_n_i = 0; lane_sel_n_i = 4'b1010;
    wdata_i = 32'h1122_3344; cycle("R9");
    idle(); wr_byte_n_i = 1; lane_sel_n_i = 4'h0; wdata_i = 32'hFFFF_FFFF; cycle("R9");
    idle(); cycle("R9"); idle(); cycle("R9");

    // both strobes with global write: read, no write
    idle(); strb_hi_n_i = 0; strb_lo_n_i = 0; addr_i = 8'h44; wr_all_n_i = 0;
    wdata_i = 32'hA5A5_A5A5; cycle("R4");
    idle(); cycle("R4"); idle(); cycle("R4");

    // high strobe with enable A high is ignored mid-burst
    lo_strobe(8'h50, "R5");
    idle(); adv_n_i = 0; strb_hi_n_i = 0; en_a_n_i = 1; addr_i = 8'h90; cycle("R5");
    idle(); adv_n_i = 0; cycle("R5"); idle(); cycle("R5");

    // output enable high masks pending data
    lo_strobe(8'h07, "R11"); idle(); oe_n_i = 1; cycle("R11");
    check("R11", rvalid_o === 1'b0 && rdata_o === 32'h0, rdata_o, 32'h0);
    idle(); cycle("R11");

    // write immediately after a read of the same word
    lo_strobe(8'h30, "R10");
    idle(); wr_all_n_i = 0; wdata_i = 32'h0BAD_F00D; cycle("R10");
    idle(); cycle("R10"); idle(); cycle("R10");

    // constrained random traffic in a small window
    for (int n = 0; n < 3000; n++) begin
      idle();
      addr_i       = ADDR_W'($urandom_range(0, 31));
      strb_hi_n_i  = ($urandom_range(0, 7) != 0);
      strb_lo_n_i  = ($urandom_range(0, 4) != 0);
      adv_n_i      = ($urandom_range(0, 2) == 0);
      en_a_n_i     = ($urandom_range(0, 9) == 0);
      en_b_i       = ($urandom_range(0, 14) != 0);
      en_c_n_i     = ($urandom_range(0, 14) == 0);
      wr_all_n_i   = ($urandom_range(0, 5) != 0);
      wr_byte_n_i  = ($urandom_range(0, 2) != 0);
      lane_sel_n_i = 4'($urandom);
      oe_n_i       = ($urandom_range(0, 9) == 0);
      wdata_i      = $urandom;
      cycle("R10");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule